// File: doc/BRIEF.md
# Processor Bus Master Unit

This unit connects a 16/32-bit CISC processor core to a 32-bit WISHBONE bus as bus master. The core posts one request at a time (a single read or write, a block read or write of whole longwords, a locked test-and-set read-modify-write, or an interrupt-acknowledge read). It holds that request until the unit pulses `done` with a status code. The unit runs the bus handshake, places byte, word and long operands on the correct big-endian byte lanes, and tags each transfer with a cycle-type code so a registered-feedback slave can prepare the next beat.

The meaning of the two abnormal terminations depends on the cycle. On memory cycles an error input ends the request as a bus error, and a retry input makes the unit drop the cycle for one clock and run the same access again. On an interrupt-acknowledge cycle an error input means a spurious interrupt, and a retry input tells the core to make its own auto-vector instead of taking one from the bus. Block write data is read live from `req_wdata`, which the core keeps matched to the beat number on `beat_idx`.

Top module: `cpu_bus_master`

## Requirements
- R1: While reset is high and on the first cycle after it, `wb_cyc_o`, `wb_stb_o`, `wb_lock_o` and `done` are low.
- R2: Byte lanes are selected big-endian, with `wb_sel_o[3]` carrying bits 31:24. Size code 0 (byte) enables only lane 3-a, where a is address bits [1:0]. Size code 1 (word) enables 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1. Size code 2 (long) enables 4'b1111.
- R3: Read data comes back to the core right-justified in `rdata`, taken from the lanes selected under R2. It is valid when `done` pulses with status 0.
- R4: Write data is taken right-justified from `req_wdata` and placed on the lanes selected under R2. Only those bytes change in the slave.
- R5: Once a request starts, strobe, address, select and write-enable stay unchanged until acknowledge, error or retry is seen. `done` is a one-cycle pulse.
- R6: An error on a memory cycle (kind 0 read, 1 write, 2 block read, 3 block write, 4 test-and-set) ends the request with status 1. A write ended this way changes no memory.
- R7: An error on an interrupt-acknowledge cycle (kind 5) ends it with status 2 (spurious).
- R8: A retry on a memory cycle removes `wb_cyc_o` for one cycle and then repeats the same address without pulsing `done`. The request later completes with status 0.
- R9: A retry on an interrupt-acknowledge cycle ends it at once with status 3 (auto-vector), and the access is not repeated.
- R10: A block request with `req_beats` = n-1 holds the strobe across n acknowledged longword beats. The word address `wb_adr_o` advances by one after each acknowledge. Every beat except the last is tagged `wb_cti_o` = 3'b010 and the last is tagged 3'b111. Each read beat pulses `beat_valid` with its data.
- R11: Test-and-set reads the addressed byte under `wb_lock_o` and keeps lock and strobe asserted into a write to the same address. That write stores the byte with bit 7 set, and `rdata` returns the original byte. A retry in either phase restarts the sequence from the read.
- R12: Single reads, single writes, test-and-set and interrupt-acknowledge cycles are tagged `wb_cti_o` = 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request pending; held until `done` |
| req_kind | input | 3 | 0 read, 1 write, 2 block read, 3 block write, 4 test-and-set, 5 interrupt acknowledge |
| req_size | input | 2 | 0 byte, 1 word, 2 long (ignored for block and test-and-set) |
| req_addr | input | 32 | Byte address of the operand |
| req_wdata | input | 32 | Right-justified write data; for block writes, the data of beat `beat_idx` |
| req_beats | input | 4 | Block length minus one |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 bus error, 2 spurious, 3 auto-vector |
| rdata | output | 32 | Right-justified read data or block-read beat data |
| beat_valid | output | 1 | Pulses with each block-read beat in `rdata` |
| beat_idx | output | 4 | Current block beat number |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_lock_o | output | 1 | Bus lock for test-and-set |
| wb_adr_o | output | 30 | Longword address |
| wb_sel_o | output | 4 | Byte lane enables |
| wb_dat_o | output | 32 | Write data |
| wb_cti_o | output | 3 | Cycle-type tag |
| wb_dat_i | input | 32 | Read data |
| wb_ack_i | input | 1 | Normal termination |
| wb_err_i | input | 1 | Error termination |
| wb_rty_i | input | 1 | Retry termination |

## Verification
The assertions assume that the slave raises at most one of acknowledge, error and retry in any cycle, and only while the strobe is high. They also assume the core keeps word operands on even addresses and long operands on aligned ones. The bench slave model draws a random wait, then asserts exactly one termination for a single cycle while the strobe is up. Its error and retry injections are aimed at a chosen termination index. The random and directed requests all use sizes and offsets that match their alignment.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [2:0] {
    K_READ = 3'd0, K_WRITE = 3'd1, K_BRD = 3'd2,
    K_BWR = 3'd3, K_TAS = 3'd4, K_IACK = 3'd5
  } kind_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_BERR = 2'd1;
  localparam logic [1:0] ST_SPUR = 2'd2;
  localparam logic [1:0] ST_AVEC = 2'd3;

  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_LAST    = 3'b111;
endpackage

// File: rtl/bmu_lanes.sv
// Big-endian lane steering: right-justified core operand <-> bus lanes.
module bmu_lanes #(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input  logic [1:0]    size,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] core_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [NL-1:0] sel,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] core_rdata
);
  int nbytes;
  int lane_lo;
  logic [DW-1:0] mask;

  always_comb begin
    nbytes  = 1 << size;
    lane_lo = NL - int'(off) - nbytes;
    if (lane_lo < 0) lane_lo = 0;
    if (nbytes >= NL) mask = '1;
    else mask = (DW'(1) << (8 * nbytes)) - DW'(1);
    bus_wdata  = (core_wdata & mask) << (8 * lane_lo);
    core_rdata = (bus_rdata >> (8 * lane_lo)) & mask;
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign sel[g] = (g >= lane_lo) && (g < lane_lo + nbytes);
  end
endmodule

// File: rtl/bmu_term.sv
// Interprets the slave termination according to the cycle type.
module bmu_term
  import bmu_pkg::*;
(
  input  logic       is_iack,
  input  logic       ack,
  input  logic       err,
  input  logic       rty,
  output logic       finish,
  output logic       again,
  output logic [1:0] code
);
  always_comb begin
    again  = rty & ~ack & ~err & ~is_iack;
    finish = ack | err | (rty & is_iack);
    if (ack)      code = ST_OK;
    else if (err) code = is_iack ? ST_SPUR : ST_BERR;
    else if (rty) code = ST_AVEC;
    else          code = ST_OK;
  end
endmodule

// File: rtl/cpu_bus_master.sv
module cpu_bus_master
  import bmu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BEAT_W = 4,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [1:0]        req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [BEAT_W-1:0] req_beats,
  output logic              done,
  output logic [1:0]        status,
  output logic [DW-1:0]     rdata,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic              wb_lock_o,
  output logic [AW-1:OW]    wb_adr_o,
  output logic [NL-1:0]     wb_sel_o,
  output logic [DW-1:0]     wb_dat_o,
  output logic [2:0]        wb_cti_o,
  input  logic [DW-1:0]     wb_dat_i,
  input  logic              wb_ack_i,
  input  logic              wb_err_i,
  input  logic              wb_rty_i
);
  localparam logic [AW-1:OW]     ADR_ONE  = {{(AW-OW-1){1'b0}}, 1'b1};
  localparam logic [BEAT_W-1:0]  BEAT_ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_GAP} state_e;

  state_e             st_q;
  kind_e              kind_q;
  logic [1:0]         size_q;
  logic [AW-1:OW]     word_q;
  logic [OW-1:0]      off_q;
  logic [BEAT_W-1:0]  left_q, idx_q;
  logic               tas_wr_q;
  logic [7:0]         tas_q;
  logic               cyc_q, stb_q, we_q, lock_q;
  logic [2:0]         cti_q;
  logic               done_q, bv_q;
  logic [1:0]         status_q;
  logic [DW-1:0]      rdata_q;

  logic               is_blk, start_blk, start_tas;
  logic [DW-1:0]      src_data, lane_rdata;
  logic               t_finish, t_again;
  logic [1:0]         t_code;
  kind_e              req_k;

  assign req_k     = kind_e'(req_kind);
  assign is_blk    = (kind_q == K_BRD) || (kind_q == K_BWR);
  assign start_blk = (req_k == K_BRD) || (req_k == K_BWR);
  assign start_tas = (req_k == K_TAS);
  assign src_data  = (kind_q == K_TAS) ? {{(DW-8){1'b0}}, tas_q | 8'h80} : req_wdata;

  bmu_lanes #(.DW(DW)) u_lanes (
    .size       (size_q),
    .off        (off_q),
    .core_wdata (src_data),
    .bus_rdata  (wb_dat_i),
    .sel        (wb_sel_o),
    .bus_wdata  (wb_dat_o),
    .core_rdata (lane_rdata)
  );

  bmu_term u_term (
    .is_iack (kind_q == K_IACK),
    .ack     (stb_q & wb_ack_i),
    .err     (stb_q & wb_err_i),
    .rty     (stb_q & wb_rty_i),
    .finish  (t_finish),
    .again   (t_again),
    .code    (t_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE;  kind_q <= K_READ;  size_q <= SZ_BYTE;
      word_q <= '0;    off_q <= '0;       left_q <= '0;  idx_q <= '0;
      tas_wr_q <= 1'b0; tas_q <= '0;
      cyc_q <= 1'b0; stb_q <= 1'b0; we_q <= 1'b0; lock_q <= 1'b0;
      cti_q <= CTI_CLASSIC;
      done_q <= 1'b0; bv_q <= 1'b0; status_q <= ST_OK; rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      bv_q   <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (req_valid && !done_q) begin
            kind_q   <= req_k;
            size_q   <= start_blk ? SZ_LONG : (start_tas ? SZ_BYTE : req_size);
            word_q   <= req_addr[AW-1:OW];
            off_q    <= start_blk ? '0 : req_addr[OW-1:0];
            left_q   <= start_blk ? req_beats : '0;
            idx_q    <= '0;
            tas_wr_q <= 1'b0;
            cyc_q    <= 1'b1;
            stb_q    <= 1'b1;
            we_q     <= (req_k == K_WRITE) || (req_k == K_BWR);
            lock_q   <= start_tas;
            cti_q    <= start_blk ? ((req_beats == '0) ? CTI_LAST : CTI_INCR) : CTI_CLASSIC;
            st_q     <= S_BUS;
          end
        end
        S_BUS: begin
          if (t_again) begin
            cyc_q  <= 1'b0;
            stb_q  <= 1'b0;
            lock_q <= 1'b0;
            if (kind_q == K_TAS) begin
              tas_wr_q <= 1'b0;
              we_q     <= 1'b0;
            end
            st_q <= S_GAP;
          end else if (t_finish) begin
            if (wb_ack_i && kind_q == K_TAS && !tas_wr_q) begin
              tas_wr_q <= 1'b1;
              we_q     <= 1'b1;
              tas_q    <= lane_rdata[7:0];
              rdata_q  <= lane_rdata;
            end else if (wb_ack_i && is_blk && left_q != '0) begin
              word_q <= word_q + ADR_ONE;
              left_q <= left_q - BEAT_ONE;
              idx_q  <= idx_q + BEAT_ONE;
              cti_q  <= (left_q == BEAT_ONE) ? CTI_LAST : CTI_INCR;
              if (!we_q) begin
                rdata_q <= lane_rdata;
                bv_q    <= 1'b1;
              end
            end else begin
              cyc_q    <= 1'b0;
              stb_q    <= 1'b0;
              lock_q   <= 1'b0;
              we_q     <= 1'b0;
              done_q   <= 1'b1;
              status_q <= t_code;
              if (wb_ack_i && !we_q) begin
                rdata_q <= lane_rdata;
                bv_q    <= is_blk;
              end
              st_q <= S_IDLE;
            end
          end
        end
        S_GAP: begin
          cyc_q  <= 1'b1;
          stb_q  <= 1'b1;
          lock_q <= (kind_q == K_TAS);
          st_q   <= S_BUS;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign status     = status_q;
  assign rdata      = rdata_q;
  assign beat_valid = bv_q;
  assign beat_idx   = idx_q;
  assign wb_cyc_o   = cyc_q;
  assign wb_stb_o   = stb_q;
  assign wb_we_o    = we_q;
  assign wb_lock_o  = lock_q;
  assign wb_adr_o   = word_q;
  assign wb_cti_o   = cti_q;
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input logic           clk,
  input logic           rst,
  input logic           done,
  input logic [1:0]     status,
  input logic           wb_cyc_o,
  input logic           wb_stb_o,
  input logic           wb_we_o,
  input logic           wb_lock_o,
  input logic [AW-1:OW] wb_adr_o,
  input logic [NL-1:0]  wb_sel_o,
  input logic [2:0]     wb_cti_o,
  input logic           wb_ack_i,
  input logic           wb_err_i,
  input logic           wb_rty_i,
  input logic [2:0]     kind
);
  localparam logic [AW-1:OW] ADR_ONE = {{(AW-OW-1){1'b0}}, 1'b1};
  logic any_term;
  assign any_term = wb_ack_i | wb_err_i | wb_rty_i;

  AST_SINGLE_TERM: assert property (@(posedge clk) disable iff (rst)
    $countones({wb_ack_i, wb_err_i, wb_rty_i}) <= 1); // R5
  AST_STB_INSIDE_CYC: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> wb_cyc_o); // R5
  AST_HOLD_UNTIL_TERM: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o && !any_term |=> wb_stb_o && $stable(wb_adr_o) && $stable(wb_sel_o) && $stable(wb_we_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_SEL_PRESENT: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> wb_sel_o != '0); // R2
  AST_MEM_ERR_STATUS: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o && wb_err_i && kind != 3'd5 |=> done && status == 2'd1); // R6
  AST_IACK_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o && wb_err_i && kind == 3'd5 |=> done && status == 2'd2); // R7
  AST_MEM_RETRY_GAP: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o && wb_rty_i && kind != 3'd5 |=> !wb_cyc_o && !done); // R8
  AST_IACK_AUTOVEC: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o && wb_rty_i && kind == 3'd5 |=> done && status == 2'd3 && !wb_cyc_o); // R9
  AST_BLOCK_STEP: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o && wb_ack_i && wb_cti_o == 3'b010 |=> wb_stb_o && wb_adr_o == $past(wb_adr_o) + ADR_ONE); // R10
  AST_LOCK_INTO_WRITE: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o && wb_lock_o && !wb_we_o && wb_ack_i |=> wb_stb_o && wb_lock_o && wb_we_o && $stable(wb_adr_o)); // R11
endmodule

bind cpu_bus_master bmu_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .status(status),
  .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_lock_o(wb_lock_o),
  .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o), .wb_cti_o(wb_cti_o),
  .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i), .wb_rty_i(wb_rty_i),
  .kind(kind_q)
);

// File: tb/cpu_bus_master_test.sv
module cpu_bus_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata;
  logic [3:0]  req_beats = '0;
  logic        done, beat_valid;
  logic [1:0]  status;
  logic [31:0] rdata;
  logic [3:0]  beat_idx;
  logic        wb_cyc_o, wb_stb_o, wb_we_o, wb_lock_o;
  logic [31:2] wb_adr_o;
  logic [3:0]  wb_sel_o;
  logic [31:0] wb_dat_o;
  logic [2:0]  wb_cti_o;
  logic [31:0] wb_dat_i = '0;
  logic        wb_ack_i = 1'b0, wb_err_i = 1'b0, wb_rty_i = 1'b0;

  logic        blk_w = 1'b0;
  logic [31:0] blk_base = '0, s_wdata = '0;
  assign req_wdata = blk_w ? (blk_base + {28'd0, beat_idx}) : s_wdata;

  cpu_bus_master uut (.*);

  int nvec = 0, nerr = 0;
  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  int wait_max = 0, wcnt = 0, cur_wait = 0;
  int inj_mode = 0, inj_at = -1, term_n = 0;
  logic [31:2] t_adr [32];
  logic [3:0]  t_sel [32];
  logic        t_we [32], t_lock [32];
  logic [2:0]  t_cti [32];
  logic [31:0] brd [16];
  int brd_n = 0;
  logic [1:0]  got_st;
  logic [31:0] got_rd;

  // slave model
  always @(negedge clk) begin
    wb_ack_i = 1'b0; wb_err_i = 1'b0; wb_rty_i = 1'b0;
    if (wb_cyc_o && wb_stb_o) begin
      if (wcnt < cur_wait) wcnt++;
      else begin
        wcnt = 0;
        cur_wait = $urandom_range(wait_max, 0);
        if (term_n == inj_at && inj_mode == 1) wb_err_i = 1'b1;
        else if (term_n == inj_at && inj_mode == 2) wb_rty_i = 1'b1;
        else begin
          wb_ack_i = 1'b1;
          if (wb_we_o)
            for (int b = 0; b < 4; b++)
              if (wb_sel_o[b]) mem[wb_adr_o[5:2]][8*b +: 8] = wb_dat_o[8*b +: 8];
        end
        if (term_n < 32) begin
          t_adr[term_n] = wb_adr_o; t_sel[term_n] = wb_sel_o; t_we[term_n] = wb_we_o;
          t_lock[term_n] = wb_lock_o; t_cti[term_n] = wb_cti_o;
        end
        term_n++;
      end
    end
    wb_dat_i = mem[wb_adr_o[5:2]];
    if (beat_valid && brd_n < 16) begin brd[brd_n] = rdata; brd_n++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] e_sel(input int size, input logic [1:0] off);
    case (size)
      0: e_sel = 4'b1000 >> off;
      1: e_sel = off[1] ? 4'b0011 : 4'b1100;
      default: e_sel = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] e_rd(input logic [31:0] w, input int size, input logic [1:0] off);
    case (size)
      0: case (off) 2'd0: e_rd = {24'd0, w[31:24]}; 2'd1: e_rd = {24'd0, w[23:16]};
                    2'd2: e_rd = {24'd0, w[15:8]};  default: e_rd = {24'd0, w[7:0]}; endcase
      1: e_rd = off[1] ? {16'd0, w[15:0]} : {16'd0, w[31:16]};
      default: e_rd = w;
    endcase
  endfunction

  function automatic logic [31:0] e_merge(input logic [31:0] old, input int size,
                                          input logic [1:0] off, input logic [31:0] wd);
    logic [31:0] placed;
    logic [3:0] s;
    case (size)
      0: placed = {4{wd[7:0]}};
      1: placed = {2{wd[15:0]}};
      default: placed = wd;
    endcase
    s = e_sel(size, off);
    e_merge = old;
    for (int b = 0; b < 4; b++) if (s[b]) e_merge[8*b +: 8] = placed[8*b +: 8];
  endfunction

  task automatic run_op(input int kind, input int size, input logic [31:0] addr,
                        input logic [31:0] wd, input int beats);
    @(negedge clk);
    req_kind = kind[2:0]; req_size = size[1:0]; req_addr = addr; s_wdata = wd;
    req_beats = 4'(beats - 1); blk_w = (kind == 3);
    term_n = 0; brd_n = 0; wcnt = 0;
    req_valid = 1'b1;
    do @(negedge clk); while (!done);
    got_st = status; got_rd = rdata;
    req_valid = 1'b0;
    @(negedge clk);
    blk_w = 1'b0; inj_mode = 0; inj_at = -1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h1000_0000 * i + 32'h0123_4567 * (i + 1);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk("R1 cyc", {31'd0, wb_cyc_o}, 0); chk("R1 stb", {31'd0, wb_stb_o}, 0);
    chk("R1 lock", {31'd0, wb_lock_o}, 0); chk("R1 done", {31'd0, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cyc after", {31'd0, wb_cyc_o}, 0); chk("R1 done after", {31'd0, done}, 0);

    // directed byte and word lanes
    for (int o = 0; o < 4; o++) begin
      run_op(1, 0, 32'h8 + o, 32'h5A + o, 1);
      shadow[2] = e_merge(shadow[2], 0, o[1:0], 32'h5A + o);
      chk("R2 byte write sel", {28'd0, t_sel[0]}, {28'd0, e_sel(0, o[1:0])});
      chk("R12 single cti", {29'd0, t_cti[0]}, 0);
      run_op(0, 0, 32'h8 + o, 0, 1);
      chk("R3 byte read", got_rd, e_rd(shadow[2], 0, o[1:0]));
    end
    chk("R4 byte lanes merged", mem[2], shadow[2]);
    for (int o = 0; o < 4; o += 2) begin
      run_op(1, 1, 32'h14 + o, 32'hBEEF_0000 + o, 1);
      shadow[5] = e_merge(shadow[5], 1, o[1:0], 32'hBEEF_0000 + o);
      chk("R4 word write", mem[5], shadow[5]);
      run_op(0, 1, 32'h14 + o, 0, 1);
      chk("R3 word read", got_rd, e_rd(shadow[5], 1, o[1:0]));
    end

    // random single accesses
    wait_max = 3;
    for (int i = 0; i < 300; i++) begin
      int sz, wi, k;
      logic [1:0] off;
      logic [31:0] wd;
      sz = $urandom_range(2, 0); wi = $urandom_range(15, 0); k = $urandom_range(1, 0);
      off = (sz == 0) ? 2'($urandom_range(3, 0)) : (sz == 1) ? {1'($urandom_range(1, 0)), 1'b0} : 2'd0;
      wd = $urandom;
      run_op(k, sz, {26'd0, wi[3:0], off}, wd, 1);
      chk("R2 random sel", {28'd0, t_sel[0]}, {28'd0, e_sel(sz, off)});
      if (k == 1) begin
        shadow[wi] = e_merge(shadow[wi], sz, off, wd);
        chk("R4 random write", mem[wi], shadow[wi]);
      end else chk("R3 random read", got_rd, e_rd(shadow[wi], sz, off));
    end
    wait_max = 1;

    // memory error
    inj_mode = 1; inj_at = 0;
    run_op(1, 2, 32'h18, 32'hDEAD_DEAD, 1);
    chk("R6 write error status", {30'd0, got_st}, 1);
    chk("R6 write error no change", mem[6], shadow[6]);
    inj_mode = 1; inj_at = 0;
    run_op(0, 2, 32'h18, 0, 1);
    chk("R6 read error status", {30'd0, got_st}, 1);

    // memory retry
    inj_mode = 2; inj_at = 0;
    run_op(0, 1, 32'h1E, 0, 1);
    chk("R8 retry status", {30'd0, got_st}, 0);
    chk("R8 retry repeats", term_n, 2);
    chk("R8 same address", {2'd0, t_adr[1]}, {2'd0, t_adr[0]});
    chk("R8 retry data", got_rd, e_rd(shadow[7], 1, 2'd2));

    // interrupt acknowledge
    inj_mode = 1; inj_at = 0;
    run_op(5, 0, 32'h0F, 0, 1);
    chk("R7 spurious", {30'd0, got_st}, 2);
    inj_mode = 2; inj_at = 0;
    run_op(5, 0, 32'h0F, 0, 1);
    chk("R9 autovector", {30'd0, got_st}, 3);
    chk("R9 no repeat", term_n, 1);
    run_op(5, 0, 32'h0F, 0, 1);
    chk("R3 vector byte", got_rd, e_rd(shadow[3], 0, 2'd3));
    chk("R12 iack cti", {29'd0, t_cti[0]}, 0);

    // block read of five beats
    run_op(2, 2, 32'h10, 0, 5);
    chk("R10 beats", brd_n, 5);
    for (int b = 0; b < 5; b++) begin
      chk("R10 block read data", brd[b], shadow[4 + b]);
      chk("R10 block address", {2'd0, t_adr[b]}, 32'(4 + b));
      chk("R10 block cti", {29'd0, t_cti[b]}, (b == 4) ? 32'd7 : 32'd2);
    end

    // block write with a retry on the third beat
    inj_mode = 2; inj_at = 2;
    run_op(3, 2, 32'h20, 0, 4);
    blk_base = 32'hC0DE_0000;
    chk("R8 block retry beats", term_n, 5);
    chk("R8 block retry address", {2'd0, t_adr[3]}, {2'd0, t_adr[2]});
    for (int b = 0; b < 4; b++) begin
      shadow[8 + b] = 32'h0000_0000 + b;
      chk("R10 block write data", mem[8 + b], 32'h0000_0000 + b);
    end
    blk_base = 32'hA5A5_0000;
    run_op(3, 2, 32'h30, 0, 1);
    chk("R10 single beat cti last", {29'd0, t_cti[0]}, 7);
    chk("R10 single beat data", mem[12], 32'hA5A5_0000);
    shadow[12] = mem[12];

    // test-and-set
    run_op(1, 0, 32'h0D, 32'h21, 1);
    shadow[3] = e_merge(shadow[3], 0, 2'd1, 32'h21);
    run_op(4, 0, 32'h0D, 0, 1);
    shadow[3] = e_merge(shadow[3], 0, 2'd1, 32'hA1);
    chk("R11 original byte", got_rd, 32'h21);
    chk("R11 bit set", mem[3], shadow[3]);
    chk("R11 lock read", {31'd0, t_lock[0]}, 1);
    chk("R11 lock write", {31'd0, t_lock[1]}, 1);
    chk("R11 write phase", {31'd0, t_we[1]}, 1);
    chk("R11 same address", {2'd0, t_adr[1]}, {2'd0, t_adr[0]});
    chk("R12 tas cti", {29'd0, t_cti[1]}, 0);
    run_op(1, 0, 32'h0E, 32'h05, 1);
    shadow[3] = e_merge(shadow[3], 0, 2'd2, 32'h05);
    inj_mode = 2; inj_at = 1;
    run_op(4, 0, 32'h0E, 0, 1);
    shadow[3] = e_merge(shadow[3], 0, 2'd2, 32'h85);
    chk("R11 retry restarts", term_n, 4);
    chk("R11 restart is read", {31'd0, t_we[2]}, 0);
    chk("R11 retry result", mem[3], shadow[3]);
    chk("R11 retry status", {30'd0, got_st}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule